// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Aggregator

This block gathers the interrupt causes of a SCSI protocol controller into two latched cause registers: one for the DMA and instruction-engine side, and one for the SCSI bus side. Each cause input is a one-cycle pulse. Pulses are ORed into their register and stay there until software reads that register. Reading a cause register returns its contents and clears them in the same access.

Two enable masks, one for each side, choose which latched causes drive a single level-sensitive interrupt line. The line stays high for as long as any enabled cause is still latched. A summary register reports two pending flags, one for the DMA side and one for the SCSI side. These flags are computed from the latched causes and ignore the masks. The summary register also takes two command bits. One forces an abort cause into the DMA cause register. The other returns the whole block to its reset state. A live DMA-FIFO-empty level is shown in the DMA cause register but is never latched.

Register map: address 0 is the summary, 1 is the DMA cause register, 2 is the SCSI cause register, 3 is the DMA enable mask and 4 is the SCSI enable mask.

Top module: `scsiIrqAgg`

## Requirements
- R1: After reset, every register reads 0 and `irqOut` is low.
- R2: A pulse on bit n of `dmaCauseIn` (n in 0..6) or of `scsiCauseIn` (n in 0..7) sets bit n of the DMA cause register (address 1) or of the SCSI cause register (address 2) on the next clock edge. Pulses accumulate by OR. DMA bit 0 is the illegal-instruction cause and DMA bit 2 is the software-interrupt cause.
- R3: A read of address 1 or address 2 returns the latched causes, and the register is cleared on the clock edge that ends the read.
- R4: A cause pulse that arrives in the same cycle as the read-clear of its register is kept and shows on the next read.
- R5: Summary bit 0 is 1 exactly when any DMA cause bit 6..0 is latched. Summary bit 1 is 1 exactly when any SCSI cause bit is latched. Neither bit depends on the enable masks.
- R6: `irqOut` is high exactly when some latched cause has its bit set in the matching enable mask (address 3 for DMA, address 4 for SCSI). It stays high until those causes are cleared.
- R7: Writing the summary register with bit 7 set latches DMA cause bit 4 (abort). Summary bits 7 and 6 read as 0.
- R8: Writing the summary register with bit 6 set clears both cause registers and both masks, including any cause pulse in that same cycle. This returns the block to the R1 state.
- R9: DMA cause bit 7 reads the live `fifoEmpty` level. A read does not clear it, it never sets summary bit 0, it never drives `irqOut`, and `dmaCauseIn` bit 7 is ignored.
- R10: The enable masks read back as written at addresses 3 and 4. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears cause registers) |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from address |
| dmaCauseIn | input | 8 | DMA-side cause pulses (bit 7 ignored) |
| scsiCauseIn | input | 8 | SCSI-side cause pulses |
| fifoEmpty | input | 1 | Live DMA FIFO empty level |
| irqOut | output | 1 | Level-sensitive interrupt request |

## Verification
The main function is tried with cause patterns that cover every mask relation:
- a cause with its enable set, and the same cause with its enable cleared;
- a mask that covers every bit except the pending one;
- causes on both sides, where only one side is enabled;
- a pulse on the ignored DMA bit 7.

Together these patterns separate the mask gating of the interrupt line from the mask-independent pending flags. Directed cases then cover the corner behaviours:
- a new cause arriving in the same cycle as a read-clear;
- the abort and reset commands;
- the FIFO-empty level, which must survive reads and stay out of the interrupt and pending logic.

// File: rtl/scsiIrqPkg.sv
package scsiIrqPkg;
  localparam int CAUSE_W = 8;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SUMMARY    = 3'd0,
    ADDR_DMA_CAUSE  = 3'd1,
    ADDR_SCSI_CAUSE = 3'd2,
    ADDR_DMA_EN     = 3'd3,
    ADDR_SCSI_EN    = 3'd4
  } regAddrE;

  // summary register bit positions
  localparam int SUM_DMA_PEND  = 0;
  localparam int SUM_SCSI_PEND = 1;
  localparam int SUM_RESET_CMD = 6;
  localparam int SUM_ABORT_CMD = 7;

  // DMA cause register bit positions
  localparam int DMA_ILLEGAL_BIT = 0;
  localparam int DMA_SOFTINT_BIT = 2;
  localparam int DMA_ABORT_BIT   = 4;
  localparam int DMA_FIFO_BIT    = 7;

  localparam int NUM_SRC = 2;
  localparam int SRC_DMA = 0;
  localparam int SRC_SCSI = 1;

  typedef struct packed {
    logic softReset;
    logic setAbort;
    logic clrDma;
    logic clrScsi;
    logic wrDmaEn;
    logic wrScsiEn;
  } ctlStrobesT;
endpackage

// File: rtl/scsiIrqCauseReg.sv
module scsiIrqCauseReg #(
  parameter int W = scsiIrqPkg::CAUSE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         softReset,
  input  logic         clrReq,
  input  logic [W-1:0] setIn,
  output logic [W-1:0] latched
);
  always_ff @(posedge clk) begin
    if (!rstN || softReset) latched <= '0;
    else                    latched <= (clrReq ? '0 : latched) | setIn;
  end
endmodule

// File: rtl/scsiIrqCtl.sv
module scsiIrqCtl
  import scsiIrqPkg::*;
#(
  parameter int W  = CAUSE_W,
  parameter int AW = ADDR_W
) (
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic [W-1:0]  regWrData,
  output ctlStrobesT    strb
);
  regAddrE addrE;
  logic    sumWrite;

  assign addrE    = regAddrE'(regAddr);
  assign sumWrite = regWrEn && (addrE == ADDR_SUMMARY);

  always_comb begin
    strb           = '0;
    strb.softReset = sumWrite && regWrData[SUM_RESET_CMD];
    strb.setAbort  = sumWrite && regWrData[SUM_ABORT_CMD] && !strb.softReset;
    strb.clrDma    = regRdEn && (addrE == ADDR_DMA_CAUSE);
    strb.clrScsi   = regRdEn && (addrE == ADDR_SCSI_CAUSE);
    strb.wrDmaEn   = regWrEn && (addrE == ADDR_DMA_EN);
    strb.wrScsiEn  = regWrEn && (addrE == ADDR_SCSI_EN);
  end
endmodule

// File: rtl/scsiIrqDatapath.sv
module scsiIrqDatapath
  import scsiIrqPkg::*;
#(
  parameter int W  = CAUSE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobesT    strb,
  input  logic [AW-1:0] regAddr,
  input  logic [W-1:0]  regWrData,
  input  logic [W-1:0]  dmaCauseIn,
  input  logic [W-1:0]  scsiCauseIn,
  input  logic          fifoEmpty,
  output logic [W-1:0]  regRdData,
  output logic [W-1:0]  dmaLatched,
  output logic [W-1:0]  scsiLatched,
  output logic          irqOut
);
  localparam logic [W-1:0] FIFO_MASK  = W'(1) << DMA_FIFO_BIT;
  localparam logic [W-1:0] DMA_LMASK  = ~FIFO_MASK;
  localparam logic [W-1:0] ABORT_MASK = W'(1) << DMA_ABORT_BIT;

  logic [NUM_SRC-1:0][W-1:0] setVec;
  logic [NUM_SRC-1:0][W-1:0] latVec;
  logic [NUM_SRC-1:0][W-1:0] enVec;
  logic [NUM_SRC-1:0]        clrVec;
  logic [NUM_SRC-1:0]        wrEnVec;
  logic [NUM_SRC-1:0]        pendVec;
  logic [NUM_SRC-1:0]        fireVec;

  assign setVec[SRC_DMA]  = (dmaCauseIn & DMA_LMASK) | (strb.setAbort ? ABORT_MASK : '0);
  assign setVec[SRC_SCSI] = scsiCauseIn;
  assign clrVec[SRC_DMA]  = strb.clrDma;
  assign clrVec[SRC_SCSI] = strb.clrScsi;
  assign wrEnVec[SRC_DMA] = strb.wrDmaEn;
  assign wrEnVec[SRC_SCSI] = strb.wrScsiEn;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    scsiIrqCauseReg #(.W(W)) i_cause (
      .clk      (clk),
      .rstN     (rstN),
      .softReset(strb.softReset),
      .clrReq   (clrVec[s]),
      .setIn    (setVec[s]),
      .latched  (latVec[s])
    );

    always_ff @(posedge clk) begin
      if (!rstN || strb.softReset) enVec[s] <= '0;
      else if (wrEnVec[s])         enVec[s] <= regWrData;
    end

    assign pendVec[s] = |latVec[s];
    assign fireVec[s] = |(latVec[s] & enVec[s]);
  end

  assign dmaLatched  = latVec[SRC_DMA];
  assign scsiLatched = latVec[SRC_SCSI];
  assign irqOut      = |fireVec;

  always_comb begin
    regRdData = '0;
    unique case (regAddrE'(regAddr))
      ADDR_SUMMARY: begin
        regRdData[SUM_DMA_PEND]  = pendVec[SRC_DMA];
        regRdData[SUM_SCSI_PEND] = pendVec[SRC_SCSI];
      end
      ADDR_DMA_CAUSE:  regRdData = latVec[SRC_DMA] | (fifoEmpty ? FIFO_MASK : '0);
      ADDR_SCSI_CAUSE: regRdData = latVec[SRC_SCSI];
      ADDR_DMA_EN:     regRdData = enVec[SRC_DMA];
      ADDR_SCSI_EN:    regRdData = enVec[SRC_SCSI];
      default:         regRdData = '0;
    endcase
  end
endmodule

// File: rtl/scsiIrqAgg.sv
module scsiIrqAgg
  import scsiIrqPkg::*;
#(
  parameter int W  = CAUSE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic [W-1:0]  regWrData,
  output logic [W-1:0]  regRdData,
  input  logic [W-1:0]  dmaCauseIn,
  input  logic [W-1:0]  scsiCauseIn,
  input  logic          fifoEmpty,
  output logic          irqOut
);
  ctlStrobesT   strb;
  logic [W-1:0] dmaLatched;
  logic [W-1:0] scsiLatched;

  scsiIrqCtl #(.W(W), .AW(AW)) i_ctl (
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb)
  );

  scsiIrqDatapath #(.W(W), .AW(AW)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .dmaCauseIn (dmaCauseIn),
    .scsiCauseIn(scsiCauseIn),
    .fifoEmpty  (fifoEmpty),
    .regRdData  (regRdData),
    .dmaLatched (dmaLatched),
    .scsiLatched(scsiLatched),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/scsiIrqAggChk.sv
module scsiIrqAggChk
  import scsiIrqPkg::*;
#(
  parameter int W  = CAUSE_W,
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic          regRdEn,
  input logic [AW-1:0] regAddr,
  input logic [W-1:0]  regWrData,
  input logic [W-1:0]  regRdData,
  input logic [W-1:0]  dmaCauseIn,
  input logic [W-1:0]  scsiCauseIn,
  input logic          fifoEmpty,
  input logic          irqOut,
  input logic [W-1:0]  dmaLatched,
  input logic [W-1:0]  scsiLatched
);
  logic sumWr;
  assign sumWr = regWrEn && (regAddr == AW'(ADDR_SUMMARY));

  // R7
  a_r7_abort_latch: assert property (@(posedge clk) disable iff (!rstN)
    sumWr && regWrData[SUM_ABORT_CMD] && !regWrData[SUM_RESET_CMD]
      |=> dmaLatched[DMA_ABORT_BIT]);

  // R3
  a_r3_dma_clear: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && !regWrEn && (regAddr == AW'(ADDR_DMA_CAUSE)) && (dmaCauseIn == '0)
      |=> (dmaLatched == '0));

  // R4
  a_r4_keep_new: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && !regWrEn && (regAddr == AW'(ADDR_SCSI_CAUSE))
      |=> (scsiLatched == $past(scsiCauseIn)));

  // R6
  a_r6_level_held: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !regRdEn && !regWrEn |=> irqOut);

  // R8
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    sumWr && regWrData[SUM_RESET_CMD]
      |=> (dmaLatched == '0) && (scsiLatched == '0) && !irqOut);

  // R5
  a_r5_pend_flags: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == AW'(ADDR_SUMMARY))
      |-> (regRdData[SUM_DMA_PEND] == |dmaLatched[DMA_FIFO_BIT-1:0])
       && (regRdData[SUM_SCSI_PEND] == |scsiLatched));

  // R9
  a_r9_fifo_quiet: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty && (dmaLatched == '0) && (scsiLatched == '0) |-> !irqOut);
endmodule

bind scsiIrqAgg scsiIrqAggChk #(.W(W), .AW(AW)) i_chk (.*);

// File: tb/test_scsiIrqAgg.sv
module test_scsiIrqAgg;
  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn, regRdEn;
  logic [2:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] dmaCauseIn, scsiCauseIn;
  logic       fifoEmpty, irqOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  scsiIrqAgg i_scsiIrqAgg (.*);

  typedef struct packed {
    logic [7:0] dIn;
    logic [7:0] sIn;
    logic [7:0] dEn;
    logic [7:0] sEn;
    logic       irq;
    logic [1:0] pend;
  } vecT;

  localparam int NV = 10;
  localparam vecT VECS [NV] = '{
    '{8'h01, 8'h00, 8'h01, 8'h00, 1'b1, 2'b01},
    '{8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 2'b01},
    '{8'h00, 8'h10, 8'h00, 8'h10, 1'b1, 2'b10},
    '{8'h00, 8'h10, 8'h00, 8'hEF, 1'b0, 2'b10},
    '{8'h04, 8'h20, 8'hFF, 8'h00, 1'b1, 2'b11},
    '{8'h80, 8'h00, 8'hFF, 8'hFF, 1'b0, 2'b00},
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 2'b00},
    '{8'h05, 8'h81, 8'h02, 8'h80, 1'b1, 2'b11},
    '{8'h40, 8'h00, 8'h40, 8'h00, 1'b1, 2'b01},
    '{8'h02, 8'h00, 8'hFD, 8'hFF, 1'b0, 2'b01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] d, input logic [7:0] s);
    @(negedge clk);
    dmaCauseIn = d; scsiCauseIn = s;
    @(negedge clk);
    dmaCauseIn = '0; scsiCauseIn = '0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    dmaCauseIn = 0; scsiCauseIn = 0; fifoEmpty = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rdReg(3'(a), rd);
      chk("R1 reg after reset", rd, 8'h00);
    end
    chk("R1 irq after reset", {7'b0, irqOut}, 8'h00);

    // main table: R2 R5 R6 R3
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'h40);
      wr(3'd3, VECS[i].dEn);
      wr(3'd4, VECS[i].sEn);
      pulse(VECS[i].dIn, VECS[i].sIn);
      chk("R6 irq level", {7'b0, irqOut}, {7'b0, VECS[i].irq});
      rdReg(3'd0, rd);
      chk("R5 pending flags", rd, {6'b0, VECS[i].pend});
      chk("R6 irq held after summary read", {7'b0, irqOut}, {7'b0, VECS[i].irq});
      rdReg(3'd1, rd);
      chk("R2 dma cause latched", rd, VECS[i].dIn & 8'h7F);
      rdReg(3'd2, rd);
      chk("R2 scsi cause latched", rd, VECS[i].sIn);
      chk("R3 irq drops after clear", {7'b0, irqOut}, 8'h00);
      rdReg(3'd0, rd);
      chk("R3 pending clear", rd, 8'h00);
    end

    // R2 accumulation by OR
    wr(3'd0, 8'h40);
    pulse(8'h01, 8'h02);
    pulse(8'h04, 8'h40);
    rdReg(3'd1, rd); chk("R2 dma accumulate", rd, 8'h05);
    rdReg(3'd2, rd); chk("R2 scsi accumulate", rd, 8'h42);

    // R4 cause in the read-clear cycle
    pulse(8'h00, 8'h01);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 3'd2; scsiCauseIn = 8'h08;
    #1 rd = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; scsiCauseIn = 8'h00;
    chk("R4 read returns old cause", rd, 8'h01);
    rdReg(3'd2, rd); chk("R4 new cause kept", rd, 8'h08);

    // R7 abort command
    wr(3'd3, 8'h10);
    wr(3'd0, 8'h80);
    chk("R7 abort raises irq", {7'b0, irqOut}, 8'h01);
    rdReg(3'd0, rd); chk("R7 command bits read 0, dma pending", rd, 8'h01);
    rdReg(3'd1, rd); chk("R7 abort bit in dma cause", rd, 8'h10);

    // R8 reset command
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
    pulse(8'h01, 8'h01);
    chk("R8 irq before reset command", {7'b0, irqOut}, 8'h01);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 8'h40; scsiCauseIn = 8'h20;
    @(negedge clk);
    regWrEn = 1'b0; scsiCauseIn = 8'h00;
    chk("R8 irq cleared", {7'b0, irqOut}, 8'h00);
    for (int a = 1; a < 5; a++) begin
      rdReg(3'(a), rd);
      chk("R8 reg cleared", rd, 8'h00);
    end

    // R9 fifo-empty live level
    wr(3'd3, 8'hFF);
    fifoEmpty = 1'b1;
    @(negedge clk);
    chk("R9 fifo does not raise irq", {7'b0, irqOut}, 8'h00);
    rdReg(3'd1, rd); chk("R9 fifo bit visible", rd, 8'h80);
    rdReg(3'd1, rd); chk("R9 fifo bit survives read", rd, 8'h80);
    rdReg(3'd0, rd); chk("R9 fifo not pending", rd, 8'h00);
    fifoEmpty = 1'b0;
    @(negedge clk);
    rdReg(3'd1, rd); chk("R9 fifo bit follows level", rd, 8'h00);

    // R10 readback and unused addresses
    wr(3'd3, 8'hA5); wr(3'd4, 8'h3C);
    rdReg(3'd3, rd); chk("R10 dma mask readback", rd, 8'hA5);
    rdReg(3'd4, rd); chk("R10 scsi mask readback", rd, 8'h3C);
    for (int a = 5; a < 8; a++) begin
      rdReg(3'(a), rd);
      chk("R10 unused address", rd, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule